// File: doc/BRIEF.md
# Unsigned absolute difference unit

This block takes two 4-bit unsigned operands and returns the magnitude of their difference, |a − b|. It has no clock and no state: the result follows the inputs through pure logic. The datapath is built from a single full-adder cell. That cell is chained into a 5-bit ripple adder, and the ripple adder is placed twice.

The first adder extends both operands to 5 bits with a leading zero. It then adds a to the bitwise complement of b, with its carry-in held at 1. The output is the signed difference as a 5-bit two's-complement word. The second adder takes that word after each bit has been XOR-ed with its sign bit. It adds zero to this word and uses the sign bit as its carry-in. So it passes a non-negative difference through unchanged and negates a negative one.

Both the intermediate difference and the 5-bit magnitude are outputs. The difference lets an integrator tell whether a wrong result comes from the subtracting stage or from the negating stage. Neither adder's carry-out takes part in the result.

Top module: `absdiff_unit`

## Requirements
- R1: For every pair of 4-bit operands, `mag_o` equals the unsigned magnitude |a_i − b_i|.
- R2: For every pair of operands, `diff_o` equals (a_i − b_i) modulo 32, that is, the 5-bit two's-complement difference.
- R3: Bit 4 of `mag_o` is always 0, so `mag_o[3:0]` holds the complete magnitude.
- R4: Bit 4 of `diff_o` (the sign bit) is 1 exactly when a_i < b_i.
- R5: When a_i ≥ b_i, `mag_o` equals `diff_o` bit for bit.
- R6: When a_i < b_i, `mag_o` + `diff_o` equals 0 modulo 32, so the magnitude is the two's-complement negation of the difference.
- R7: Equal operands give `diff_o` = 00000 and `mag_o` = 00000.
- R8: Known vectors:
  - a=0110, b=1101 gives diff_o=11001 and mag_o=00111.
  - a=1110, b=0101 gives mag_o=01001.
  - a=0001, b=1111 gives mag_o=01110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | Minuend, unsigned |
| b_i | input | 4 | Subtrahend, unsigned |
| diff_o | output | 5 | Intermediate a_i − b_i, 5-bit two's complement |
| mag_o | output | 5 | Absolute difference; bit 4 is always 0 |

## Verification
The subtract stage and the conditional negate stage both act on every input change. A fault in one stage can therefore be hidden or confused with a fault in the other. The bench drives each operand pair, including the zero-difference and sign-boundary cases, and checks `diff_o` and `mag_o` separately against their own expected values. It also checks that bit 4 of the magnitude stays clear. A fault is then attributed to the stage whose output is wrong.

// File: rtl/absdiff_pkg.sv
package absdiff_pkg;
    parameter int unsigned OPND_W = 4;
    localparam int unsigned WIDE_W = OPND_W + 1;
    typedef logic [OPND_W-1:0] opnd_t;
    typedef logic [WIDE_W-1:0] wide_t;
endpackage

// File: rtl/absdiff_fa_cell.sv
module absdiff_fa_cell (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    logic half;

    always_comb begin
        half = x_i ^ y_i;
        s_o  = half ^ c_i;
        c_o  = (x_i & y_i) | (c_i & half);
    end
endmodule

// File: rtl/absdiff_ripple_add.sv
module absdiff_ripple_add #(
    parameter int unsigned W = 5
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] carry;

    assign carry[0] = cin_i;

    for (genvar g = 0; g < W; g++) begin : g_cell
        absdiff_fa_cell u_fa (
            .x_i (x_i[g]),
            .y_i (y_i[g]),
            .c_i (carry[g]),
            .s_o (sum_o[g]),
            .c_o (carry[g+1])
        );
    end

    assign cout_o = carry[W];
endmodule

// File: rtl/absdiff_unit.sv
module absdiff_unit
    import absdiff_pkg::*;
(
    input  logic [3:0] a_i,
    input  logic [3:0] b_i,
    output logic [4:0] diff_o,
    output logic [4:0] mag_o
);
    localparam int unsigned MSB = WIDE_W - 1;

    wide_t a_wide;
    wide_t b_inv;
    wide_t diff_w;
    wide_t flip_w;
    wide_t mag_w;
    logic  sign;
    logic  sub_carry;
    logic  neg_carry;

    // Zero-extend both operands; complement the subtrahend.
    assign a_wide = {1'b0, a_i};
    assign b_inv  = ~{1'b0, b_i};

    absdiff_ripple_add #(.W(WIDE_W)) u_sub (
        .x_i    (a_wide),
        .y_i    (b_inv),
        .cin_i  (1'b1),
        .sum_o  (diff_w),
        .cout_o (sub_carry)
    );

    // Conditional negation: XOR with the sign, then add the sign.
    assign sign   = diff_w[MSB];
    assign flip_w = diff_w ^ {WIDE_W{sign}};

    absdiff_ripple_add #(.W(WIDE_W)) u_neg (
        .x_i    (flip_w),
        .y_i    ('0),
        .cin_i  (sign),
        .sum_o  (mag_w),
        .cout_o (neg_carry)
    );

    assign diff_o = diff_w;
    assign mag_o  = mag_w;

    // Checks across the two adder stages.
    always_comb begin
        if (!$isunknown({a_i, b_i, diff_o, mag_o, sub_carry, neg_carry})) begin
            p_mag_msb_clear_r3: assert (mag_o[4] == 1'b0)
                else $error("R3: magnitude bit 4 set");
            p_no_overflow_r3: assert (neg_carry == 1'b0)
                else $error("R3: negate stage carried out");
            p_sign_vs_order_r4: assert (diff_o[4] == (a_i < b_i))
                else $error("R4: sign bit disagrees with operand order");
            p_borrow_r4: assert (sub_carry == (a_i >= b_i))
                else $error("R4: subtract carry disagrees with operand order");
            if (!diff_o[4]) begin
                p_pos_pass_r5: assert (mag_o == diff_o)
                    else $error("R5: non-negative difference altered");
            end else begin
                p_neg_sum_r6: assert (5'(mag_o + diff_o) == 5'd0)
                    else $error("R6: magnitude is not the negation");
            end
        end
    end
endmodule

// File: tb/absdiff_unit_tb.sv
module absdiff_unit_tb_top;
    typedef struct {
        logic [3:0] a;
        logic [3:0] b;
        logic [4:0] exp_d;
        logic [4:0] exp_m;
    } item_t;

    logic       clk = 1'b0;
    logic [3:0] a_s = '0;
    logic [3:0] b_s = '0;
    logic [4:0] diff_s;
    logic [4:0] mag_s;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;
    item_t      q[$];

    always #4 clk = ~clk;

    absdiff_unit dut_i (
        .a_i    (a_s),
        .b_i    (b_s),
        .diff_o (diff_s),
        .mag_o  (mag_s)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act[4:0], exp[4:0]);
        end
    endtask

    task automatic drive(input logic [3:0] a, input logic [3:0] b);
        item_t it;
        int    d;
        @(posedge clk);
        a_s = a;
        b_s = b;
        d = int'(a) - int'(b);
        it.a = a;
        it.b = b;
        it.exp_d = 5'(d);
        it.exp_m = 5'(d < 0 ? -d : d);
        q.push_back(it);
    endtask

    // Monitor: compares at the falling edge, after the inputs have settled.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            chk(mag_s == it.exp_m, "R1 magnitude", int'(mag_s), int'(it.exp_m));
            chk(diff_s == it.exp_d, "R2 difference", int'(diff_s), int'(it.exp_d));
            chk(mag_s[4] == 1'b0, "R3 msb clear", int'(mag_s), int'(it.exp_m));
            chk(diff_s[4] == (it.a < it.b), "R4 sign", int'(diff_s), int'(it.exp_d));
            if (it.a >= it.b)
                chk(mag_s == diff_s, "R5 pass-through", int'(mag_s), int'(diff_s));
            else
                chk(5'(mag_s + diff_s) == 5'd0, "R6 negation", int'(mag_s), int'(5'(-diff_s)));
            if (it.a == it.b)
                chk(diff_s == 5'd0 && mag_s == 5'd0, "R7 equal operands",
                    int'(mag_s), 0);
            if (it.a == 4'b0110 && it.b == 4'b1101) begin
                chk(diff_s == 5'b11001, "R8 vector diff", int'(diff_s), 5'b11001);
                chk(mag_s == 5'b00111, "R8 vector mag", int'(mag_s), 5'b00111);
            end
            if (it.a == 4'hE && it.b == 4'h5)
                chk(mag_s == 5'b01001, "R8 vector E-5", int'(mag_s), 5'b01001);
            if (it.a == 4'h1 && it.b == 4'hF)
                chk(mag_s == 5'b01110, "R8 vector 1-F", int'(mag_s), 5'b01110);
        end
    end

    initial begin
        // Known vectors first, then every operand pair.
        drive(4'b0110, 4'b1101);
        drive(4'hE, 4'h5);
        drive(4'h1, 4'hF);
        drive(4'hB, 4'h7);
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                drive(4'(i), 4'(j));
            end
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule